// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C) that behaves like a byte-wide serial EEPROM with a 16-bit word address. It watches the clock and data lines and detects start and stop conditions from them. It answers only to a device byte whose two select bits match its strapped select inputs, so up to four copies can share one bus. The storage is an internal register array. Its depth is a parameter, and word addresses are folded modulo that depth.

Writes move through a page buffer. A write transaction sets a word address and then streams data bytes. Only the low page-offset bits of the address step between bytes, so a long burst wraps inside its page. The buffered bytes are copied into the array only when the master sends a stop, and only after a timed write cycle whose length is set in clock cycles by a parameter. While that cycle runs, the device does not acknowledge its address, so a master can poll for completion.

Reads return bytes from an address counter. That counter runs across the whole array and wraps from the top back to zero. A read can start at the current counter value, or after a dummy write that loads a new address followed by a repeated start. The data line is driven open-drain through an enable that only pulls it low. A write-protect input keeps the array from changing.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe` is low, every array location reads 0x00 and the address counter is zero.
- R2: The device byte is sent MSB first as 1,0,1,0,0,S1,S0,RW. It is acknowledged (data held low through the ninth clock) only when S1,S0 equal `sel_i[1:0]` and the upper five bits are 10100. Any other device byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: After an acknowledged device byte with RW=0, two word-address bytes follow, high byte first, and each is acknowledged. The address counter then holds the 16-bit word address modulo MEM_DEPTH.
- R4: Each data byte of a write is acknowledged and lands at the counter. Only the low PAGE_BITS counter bits then increment, wrapping to the start of the same page. If two bytes of one burst hit the same location, the later one wins.
- R5: Written bytes reach the array only after a stop, at the end of a write cycle WR_CYCLES clocks long. During that cycle every device byte gets no acknowledge, and after it the device byte is acknowledged again.
- R6: A random read (a dummy write of the word address, a repeated start, then a device byte with RW=1) returns the byte stored at that word address.
- R7: In a read, a master acknowledge (data low on the ninth clock) makes the block send the next byte. The counter steps through the whole array and wraps from MEM_DEPTH-1 to 0. A master no-acknowledge ends the transfer.
- R8: A current-address read (device byte with RW=1 straight after a start) returns the byte at the counter, which is one past the last location read.
- R9: While `wp_i` is high, data bytes are acknowledged but not stored. No write cycle starts, so the device byte is acknowledged right after the stop, and the array is unchanged.
- R10: `sda_oe` high pulls the data line low, and it rises only while the clock line is low.
- R11: A start received before the stop discards any buffered data bytes. Nothing is written and no write cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When high, the data line is pulled low |
| sel_i | input | 2 | Strapped chip-select value compared with the device byte |
| wp_i | input | 1 | Write protect, high blocks array changes |

## Verification
The assertions assume that the bus clock is slow next to `clk`, so every line level lasts longer than the synchronizer and filter delay. They also assume the master moves the data line only while the clock line is low, except to form a start or a stop. The bench drives each quarter bit for eight system clocks and changes data only with the clock low. Its line model is the wired-AND of the master's pull-down and `sda_oe`. The stimulus covers all sixteen select pairings, a page burst that wraps and overwrites, a full-array fill followed by a read that wraps past the top, protected writes and an aborted write.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } eep_st_t;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_DATA
   } eep_ph_t;

   localparam logic [4:0] DEV_TAG = 5'b10100;
endpackage

// File: rtl/eep_line_cond.sv
module eep_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILTER      = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] scl_sh, sda_sh;
   logic         scl_f, sda_f, scl_q, sda_q;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
      end else begin
         scl_sh <= {scl_sh[TOP-1:0], scl_i};
         sda_sh <= {sda_sh[TOP-1:0], sda_i};
      end
   end

   if (FILTER != 0) begin : g_vote
      logic scl_p, sda_p;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            scl_f <= 1'b1;
            sda_f <= 1'b1;
         end else begin
            scl_p <= scl_sh[TOP];
            sda_p <= sda_sh[TOP];
            if (scl_p == scl_sh[TOP]) scl_f <= scl_p;
            if (sda_p == sda_sh[TOP]) sda_f <= sda_p;
         end
      end
   end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_f <= 1'b1;
            sda_f <= 1'b1;
         end else begin
            scl_f <= scl_sh[TOP];
            sda_f <= sda_sh[TOP];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_lvl   = scl_f;
   assign sda_lvl   = sda_f;
   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
   assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PAGE_BITS = 7,
   parameter int BASE_W    = 2,
   parameter int WR_CYCLES = 4000,
   parameter int PAGE      = 1 << PAGE_BITS,
   parameter int CW        = $clog2(WR_CYCLES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 go,
   input  logic                 wr_en,
   input  logic [PAGE_BITS-1:0] wr_idx,
   input  logic [7:0]           wr_data,
   input  logic [BASE_W-1:0]    wr_base,
   output logic                 busy,
   output logic                 commit,
   output logic [BASE_W-1:0]    cm_base,
   output logic [PAGE*8-1:0]    cm_data,
   output logic [PAGE-1:0]      cm_valid
);
   logic [7:0]        slot [PAGE];
   logic [PAGE-1:0]   vld;
   logic [BASE_W-1:0] base;
   logic [CW-1:0]     cnt;
   logic              busy_q;

   initial begin
      assert (WR_CYCLES >= 1) else $error("WR_CYCLES must be positive");
   end

   assign commit = busy_q && (cnt == CW'(WR_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= '0;
         base   <= '0;
         cnt    <= '0;
         busy_q <= 1'b0;
      end else if (busy_q) begin
         if (commit) begin
            busy_q <= 1'b0;
            vld    <= '0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (clr) begin
         vld <= '0;
      end else if (go && (|vld)) begin
         busy_q <= 1'b1;
         cnt    <= '0;
      end else if (wr_en) begin
         vld[wr_idx] <= 1'b1;
         base        <= wr_base;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !busy_q) slot[wr_idx] <= wr_data;
   end

   for (genvar i = 0; i < PAGE; i++) begin : g_pack
      assign cm_data[i*8 +: 8] = slot[i];
   end

   assign cm_valid = vld;
   assign cm_base  = base;
   assign busy     = busy_q;

   // R5
   busy_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !wr_en);

   // R5
   cycle_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(go));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int DEPTH     = 512,
   parameter int PAGE_BITS = 7,
   parameter int AW        = $clog2(DEPTH),
   parameter int BASE_W    = AW - PAGE_BITS,
   parameter int PAGE      = 1 << PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [7:0]        rd_data,
   input  logic              commit,
   input  logic [BASE_W-1:0] cm_base,
   input  logic [PAGE*8-1:0] cm_data,
   input  logic [PAGE-1:0]   cm_valid
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= 8'h00;
      end else if (commit) begin
         for (int i = 0; i < PAGE; i++) begin
            if (cm_valid[i]) mem[{cm_base, PAGE_BITS'(i)}] <= cm_data[i*8 +: 8];
         end
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
   import eep_pkg::*;
#(
   parameter int MEM_DEPTH   = 512,
   parameter int PAGE_BITS   = 7,
   parameter int WR_CYCLES   = 4000,
   parameter int SYNC_STAGES = 2,
   parameter int FILTER      = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [1:0] sel_i,
   input  logic       wp_i
);
   localparam int AW     = $clog2(MEM_DEPTH);
   localparam int BASE_W = AW - PAGE_BITS;
   localparam int PAGE   = 1 << PAGE_BITS;

   initial begin
      assert ((1 << AW) == MEM_DEPTH) else $error("MEM_DEPTH must be a power of two");
      assert (MEM_DEPTH > PAGE) else $error("MEM_DEPTH must exceed one page");
      assert (AW <= 16) else $error("MEM_DEPTH exceeds the 16-bit word address");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

   eep_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILTER(FILTER)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop)
   );

   eep_st_t        st;
   eep_ph_t        ph;
   logic [2:0]     bitcnt;
   logic           rx_full;
   logic [7:0]     sreg;
   logic [7:0]     addr_hi;
   logic [AW-1:0]  addr_cnt;
   logic           to_tx;
   logic [6:0]     txsh;
   logic           mack;
   logic           oe;

   logic           busy, commit;
   logic [BASE_W-1:0] cm_base;
   logic [PAGE*8-1:0] cm_data;
   logic [PAGE-1:0]   cm_valid;
   logic [7:0]        rd_data;

   logic           decide, dev_hit, wr_en, tx_load;
   logic [15:0]    word_addr;
   logic           unused_word;
   logic [AW-1:0]  addr_pg_next;

   assign decide    = (st == ST_RX) && scl_fall && rx_full;
   assign dev_hit   = (sreg[7:3] == DEV_TAG) && (sreg[2:1] == sel_i) && !busy;
   assign wr_en     = decide && (ph == PH_DATA) && !wp_i;
   assign tx_load   = ((st == ST_RACK) && scl_fall && to_tx) ||
                      ((st == ST_TACK) && scl_fall && mack);
   assign word_addr = {addr_hi, sreg};
   assign unused_word = ^word_addr;
   assign addr_pg_next = {addr_cnt[AW-1:PAGE_BITS],
                          addr_cnt[PAGE_BITS-1:0] + PAGE_BITS'(1)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ph       <= PH_DEV;
         bitcnt   <= '0;
         rx_full  <= 1'b0;
         sreg     <= '0;
         addr_hi  <= '0;
         addr_cnt <= '0;
         to_tx    <= 1'b0;
         txsh     <= '0;
         mack     <= 1'b0;
         oe       <= 1'b0;
      end else if (bus_start) begin
         st      <= ST_RX;
         ph      <= PH_DEV;
         bitcnt  <= '0;
         rx_full <= 1'b0;
         oe      <= 1'b0;
      end else if (bus_stop) begin
         st      <= ST_IDLE;
         rx_full <= 1'b0;
         oe      <= 1'b0;
      end else begin
         unique case (st)
            ST_RX: begin
               if (scl_rise && !rx_full) begin
                  sreg   <= {sreg[6:0], sda_lvl};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) rx_full <= 1'b1;
               end else if (decide) begin
                  rx_full <= 1'b0;
                  bitcnt  <= '0;
                  unique case (ph)
                     PH_DEV: begin
                        if (dev_hit) begin
                           oe    <= 1'b1;
                           st    <= ST_RACK;
                           to_tx <= sreg[0];
                           if (!sreg[0]) ph <= PH_AHI;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_AHI: begin
                        oe      <= 1'b1;
                        st      <= ST_RACK;
                        addr_hi <= sreg;
                        ph      <= PH_ALO;
                     end
                     PH_ALO: begin
                        oe       <= 1'b1;
                        st       <= ST_RACK;
                        addr_cnt <= word_addr[AW-1:0];
                        ph       <= PH_DATA;
                     end
                     PH_DATA: begin
                        oe       <= 1'b1;
                        st       <= ST_RACK;
                        addr_cnt <= addr_pg_next;
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
            end
            ST_RACK: begin
               if (scl_fall) begin
                  if (to_tx) begin
                     st       <= ST_TX;
                     txsh     <= rd_data[6:0];
                     oe       <= ~rd_data[7];
                     bitcnt   <= '0;
                     addr_cnt <= addr_cnt + 1'b1;
                  end else begin
                     oe <= 1'b0;
                     st <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     oe <= 1'b0;
                     st <= ST_TACK;
                  end else begin
                     oe     <= ~txsh[6];
                     txsh   <= {txsh[5:0], 1'b0};
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
            end
            ST_TACK: begin
               if (scl_rise) begin
                  mack <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (mack) begin
                     st       <= ST_TX;
                     txsh     <= rd_data[6:0];
                     oe       <= ~rd_data[7];
                     bitcnt   <= '0;
                     addr_cnt <= addr_cnt + 1'b1;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe = oe;

   eep_page_buf #(.PAGE_BITS(PAGE_BITS), .BASE_W(BASE_W), .WR_CYCLES(WR_CYCLES)) u_pbuf (
      .clk(clk), .rst_n(rst_n), .clr(bus_start), .go(bus_stop), .wr_en(wr_en),
      .wr_idx(addr_cnt[PAGE_BITS-1:0]), .wr_data(sreg), .wr_base(addr_cnt[AW-1:PAGE_BITS]),
      .busy(busy), .commit(commit), .cm_base(cm_base), .cm_data(cm_data), .cm_valid(cm_valid)
   );

   eep_array #(.DEPTH(MEM_DEPTH), .PAGE_BITS(PAGE_BITS)) u_mem (
      .clk(clk), .rst_n(rst_n), .rd_addr(addr_cnt), .rd_data(rd_data),
      .commit(commit), .cm_base(cm_base), .cm_data(cm_data), .cm_valid(cm_valid)
   );

   // R10
   oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> !scl_lvl);

   // R4
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> addr_cnt[AW-1:PAGE_BITS] == $past(addr_cnt[AW-1:PAGE_BITS]));

   // R7
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> addr_cnt == AW'($past(addr_cnt) + 1'b1));

   // R2
   nack_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && ph == PH_DEV && sreg[2:1] != sel_i) |=> !oe);
endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
   localparam int DEPTH = 64;
   localparam int PB    = 3;
   localparam int PAGE  = 1 << PB;
   localparam int WRC   = 600;
   localparam int Q     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic [1:0] sel = 2'b10;
   logic wp = 1'b0;
   logic sda_oe;
   wire  sda_bus = ~(m_low | sda_oe);

   int total = 0;
   int bad = 0;
   int r10_viol = 0;
   logic [7:0] model [DEPTH];

   always #2 clk = ~clk;

   serial_eeprom_slave #(.MEM_DEPTH(DEPTH), .PAGE_BITS(PB), .WR_CYCLES(WRC)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .sel_i(sel), .wp_i(wp)
   );

   // R10 monitor: enable may only rise while the clock line is low
   logic oe_prev = 1'b0;
   always @(posedge clk) begin
      if (sda_oe && !oe_prev && scl) r10_viol++;
      oe_prev <= sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic qw;
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start;
      m_low = 1'b0; qw; scl = 1'b1; qw; m_low = 1'b1; qw; scl = 1'b0; qw;
   endtask

   task automatic bus_stop;
      m_low = 1'b1; qw; scl = 1'b1; qw; m_low = 1'b0; qw; qw;
   endtask

   task automatic send_bit(input logic b);
      m_low = ~b; qw; scl = 1'b1; qw; qw; scl = 1'b0; qw;
   endtask

   task automatic recv_bit(output logic b);
      m_low = 1'b0; qw; scl = 1'b1; qw; b = sda_bus; qw; scl = 1'b0; qw;
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack);
   endtask

   function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
      return {5'b10100, s, rw};
   endfunction

   task automatic poll(output int n);
      logic ack;
      n = 0;
      for (int t = 0; t < 20; t++) begin
         bus_start;
         send_byte(dev(sel, 1'b0), ack);
         bus_stop;
         if (ack) break;
         n++;
      end
   endtask

   task automatic write_burst(input int hi, input int start, input int cnt, input int seed,
                              input string tag);
      logic ack;
      int a;
      bus_start;
      send_byte(dev(sel, 1'b0), ack);
      chk(ack, {tag, " dev ack"}, ack, 1);
      send_byte(8'(hi), ack);
      chk(ack, "R3 high address ack", ack, 1);
      send_byte(8'(start), ack);
      chk(ack, "R3 low address ack", ack, 1);
      for (int i = 0; i < cnt; i++) begin
         a = (start % DEPTH) - (start % PAGE) + ((start + i) % PAGE);
         send_byte(8'((seed == 0) ? (a * 37 + 11) : (seed + i)), ack);
         chk(ack, "R4 data ack", ack, 1);
         model[a] = 8'((seed == 0) ? (a * 37 + 11) : (seed + i));
      end
      bus_stop;
   endtask

   task automatic read_from(input int start, input int cnt, input string tag);
      logic ack;
      logic [7:0] v;
      bus_start;
      send_byte(dev(sel, 1'b0), ack);
      send_byte(8'(start >> 8), ack);
      send_byte(8'(start), ack);
      bus_start;
      send_byte(dev(sel, 1'b1), ack);
      chk(ack, {tag, " read dev ack"}, ack, 1);
      for (int k = 0; k < cnt; k++) begin
         recv_byte(v, k != cnt - 1);
         chk(v == model[(start + k) % DEPTH], tag, v, model[(start + k) % DEPTH]);
      end
      bus_stop;
   endtask

   task automatic main_flow;
      logic ack;
      logic [7:0] v;
      int n;
      for (int k = 0; k < DEPTH; k++) model[k] = 8'h00;
      repeat (10) @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe == 1'b0, "R1 enable low after reset", sda_oe, 0);
      read_from(13, 1, "R1 array cleared");

      // R2: every strap against every select field
      for (int s = 0; s < 4; s++) begin
         sel = 2'(s);
         for (int a = 0; a < 4; a++) begin
            bus_start;
            send_byte(dev(2'(a), 1'b0), ack);
            bus_stop;
            chk(ack == (a == s), "R2 select match", ack, int'(a == s));
         end
      end
      sel = 2'b10;
      bus_start;
      send_byte(8'hB4, ack);
      bus_stop;
      chk(!ack, "R2 wrong type nibble", ack, 0);
      bus_start;
      send_byte(8'hAC, ack);
      bus_stop;
      chk(!ack, "R2 bit three set", ack, 0);

      // R3 R5: single byte write with a folded high address byte
      write_burst(8'h12, 8'h05, 1, 8'hA5, "R3");
      poll(n);
      chk(n >= 1 && n <= 4, "R5 busy polls", n, 1);
      read_from(5, 1, "R6 random read");

      // R4: fill every page starting mid-page
      for (int p = 0; p < DEPTH / PAGE; p++) begin
         write_burst(0, p * PAGE + 3, PAGE, 0, "R4");
         poll(n);
         chk(n >= 1, "R5 write cycle seen", n, 1);
      end
      // R4: burst longer than a page overwrites its own start
      write_burst(0, 2 * PAGE + 6, PAGE + 2, 8'hC0, "R4");
      poll(n);

      // R7: whole array plus wrap past the top
      read_from(0, DEPTH + 2, "R7 sequential");

      // R8: current address reads
      bus_start;
      send_byte(dev(sel, 1'b1), ack);
      recv_byte(v, 1'b0);
      bus_stop;
      chk(v == model[2], "R8 current address", v, model[2]);
      bus_start;
      send_byte(dev(sel, 1'b1), ack);
      recv_byte(v, 1'b0);
      bus_stop;
      chk(v == model[3], "R8 current address next", v, model[3]);

      // R9: protected write
      wp = 1'b1;
      bus_start;
      send_byte(dev(sel, 1'b0), ack);
      send_byte(8'h00, ack);
      send_byte(8'd40, ack);
      send_byte(~model[40], ack);
      chk(ack, "R9 protected data ack", ack, 1);
      bus_stop;
      poll(n);
      chk(n == 0, "R9 no write cycle", n, 0);
      wp = 1'b0;
      read_from(40, 1, "R9 array unchanged");

      // R11: repeated start discards buffered bytes
      bus_start;
      send_byte(dev(sel, 1'b0), ack);
      send_byte(8'h00, ack);
      send_byte(8'd9, ack);
      send_byte(~model[9], ack);
      bus_start;
      send_byte(dev(sel, 1'b0), ack);
      bus_stop;
      poll(n);
      chk(n == 0, "R11 no write cycle", n, 0);
      read_from(9, 1, "R11 byte kept");

      chk(r10_viol == 0, "R10 enable rose with clock high", r10_viol, 0);
      chk(sda_oe == 1'b0, "R10 released when idle", sda_oe, 0);
   endtask

   initial begin
      fork
         main_flow;
         begin
            repeat (190000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog act=expired exp=done");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule